// File: doc/BRIEF.md
# Sync-Aligned Clock Divider Control

This block produces a divided clock-enable pulse from a programmable counter and lets an external, asynchronous alignment input reset the counter's phase. Several such dividers fed from one shared alignment signal can then be brought into a known phase relationship with each other. Software configures the block through a small byte-wide register port. The port has a write strobe and a combinational read-back.

The alignment input first passes through a synchronizer. It is then qualified in one of three ways: by a high level, by a rising edge or by a falling edge. A qualified event realigns the divider only when two enable bits are set: a master enable and a divider-alignment enable. In continuous mode every qualified event realigns the divider. In one-shot mode only the first qualified event is accepted. The hardware then clears the divider-alignment enable itself, so later events are ignored until software sets the bit again.

Top module: `sync_div_align`

## Requirements
- R1: After reset, the control register (address 0x3A) and the pin register (address 0x59) both read 0x00, and the divide counter starts at 0.
- R2: With no alignment, `clkEn` is high for one cycle in every N cycles, where N = `divRatio` + 1 (1 to 8). It is high in the cycle in which the counter equals `divRatio`, and the counter then wraps to 0. With N = 1, `clkEn` stays high.
- R3: While control bit 0 (master enable) is 0, `syncIn` has no effect. The divider keeps counting freely, and control bit 1 is never cleared.
- R4: While control bit 1 (divider alignment enable) is 0, `syncIn` has no effect on the divider, even with the master enable set.
- R5: With control bits 0 and 1 set and bit 2 (one-shot) clear, every qualified event realigns the divider. `syncIn` passes through two synchronizer flops, so a change of `syncIn` forces the counter to 0 at the third rising clock edge after the change. Control bit 1 stays set in this mode.
- R6: With control bits 0, 1 and 2 all set, the first qualified event realigns the divider and hardware clears control bit 1 at the same edge. Reading 0x3A afterwards returns bit 1 as 0, and later events are ignored.
- R7: With pin bit 1 (edge mode) at 0, a high synchronized level qualifies. The counter is held at 0 for as long as the level persists.
- R8: With pin bit 1 = 1 and pin bit 0 = 1, only a rising edge of the synchronized input qualifies. Each edge realigns the divider once.
- R9: With pin bit 1 = 1 and pin bit 0 = 0, only a falling edge of the synchronized input qualifies.
- R10: Reserved bits read 0: bits 7 to 3 of 0x3A and bits 7 to 2 of 0x59, even after 0xFF is written. Any other address reads 0x00.
- R11: If a software write to 0x3A and a one-shot self-clear fall on the same clock edge, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address for writes and read-back |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regRdData | output | 8 | Combinational read-back of the register at `regAddr` |
| syncIn | input | 1 | Asynchronous alignment input |
| divRatio | input | 3 | Divide ratio minus one |
| clkEn | output | 1 | Divided clock-enable pulse |

## Verification
Two functions can act on control bit 1 on the same clock edge: a software write to address 0x3A and the hardware self-clear that follows a one-shot realignment. The bench sets up rising-edge one-shot mode and raises `syncIn`. It then places the write strobe exactly on the edge where the synchronized rising edge is seen. The write must win, so the read-back must still show bit 1 set. The realignment must also have happened, which the bench confirms from the phase of the `clkEn` pulses against an independent cycle model.

// File: rtl/sync_div_pkg.sv
package sync_div_pkg;

  // Decoded configuration held by the control register file
  typedef struct packed {
    logic masterEn;
    logic divSyncEn;
    logic nextOnly;
    logic edgeMode;
    logic risingSel;
  } syncCfg_t;

  // Strobes passed from control to the divider datapath
  typedef struct packed {
    logic realign;
  } divStrobe_t;

endpackage

// File: rtl/sync_div_ctrl.sv
module sync_div_ctrl
  import sync_div_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CTRL_ADDR   = 'h3A,
  parameter int unsigned PIN_ADDR    = 'h59,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              syncIn,
  output syncCfg_t          cfgOut,
  output divStrobe_t        strobeOut
);

  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] PIN_SEL  = ADDR_W'(PIN_ADDR);
  localparam int unsigned       LAST     = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncNow;
  logic                   syncPrev;
  logic                   qualHit;
  logic                   realignNow;
  logic                   ctrlWrite;
  logic                   pinWrite;
  syncCfg_t               cfgQ;

  // Multi-flop synchronizer for the asynchronous alignment input
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= syncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else       syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign syncNow = syncChain[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncNow;
  end

  // Qualification: level, rising or falling edge
  always_comb begin
    if (!cfgQ.edgeMode)      qualHit = syncNow;
    else if (cfgQ.risingSel) qualHit = syncNow & ~syncPrev;
    else                     qualHit = ~syncNow & syncPrev;
  end

  assign realignNow = cfgQ.masterEn & cfgQ.divSyncEn & qualHit;
  assign ctrlWrite  = regWrEn && (regAddr == CTRL_SEL);
  assign pinWrite   = regWrEn && (regAddr == PIN_SEL);

  // Register file; a write beats the one-shot self-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      if (ctrlWrite) begin
        cfgQ.masterEn  <= regWrData[0];
        cfgQ.divSyncEn <= regWrData[1];
        cfgQ.nextOnly  <= regWrData[2];
      end else if (realignNow && cfgQ.nextOnly) begin
        cfgQ.divSyncEn <= 1'b0;
      end
      if (pinWrite) begin
        cfgQ.risingSel <= regWrData[0];
        cfgQ.edgeMode  <= regWrData[1];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_SEL)
      regRdData = DATA_W'({cfgQ.nextOnly, cfgQ.divSyncEn, cfgQ.masterEn});
    else if (regAddr == PIN_SEL)
      regRdData = DATA_W'({cfgQ.edgeMode, cfgQ.risingSel});
  end

  assign cfgOut            = cfgQ;
  assign strobeOut.realign = realignNow;

endmodule

// File: rtl/sync_div_counter.sv
module sync_div_counter
  import sync_div_pkg::*;
#(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] divRatio,
  input  divStrobe_t         strobeIn,
  output logic               clkEn,
  output logic [RATIO_W-1:0] countOut
);

  logic [RATIO_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN)                  countQ <= '0;
    else if (strobeIn.realign)  countQ <= '0;
    else if (countQ >= divRatio) countQ <= '0;
    else                        countQ <= countQ + 1'b1;
  end

  assign clkEn    = (countQ == divRatio);
  assign countOut = countQ;

endmodule

// File: rtl/sync_div_align.sv
module sync_div_align
  import sync_div_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RATIO_W     = 3,
  parameter int unsigned CTRL_ADDR   = 'h3A,
  parameter int unsigned PIN_ADDR    = 'h59,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regWrEn,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               syncIn,
  input  logic [RATIO_W-1:0] divRatio,
  output logic               clkEn
);

  syncCfg_t           cfgBus;
  divStrobe_t         strobeBus;
  logic [RATIO_W-1:0] countQ;

  sync_div_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .PIN_ADDR(PIN_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .syncIn(syncIn),
    .cfgOut(cfgBus), .strobeOut(strobeBus)
  );

  sync_div_counter #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .strobeIn(strobeBus),
    .clkEn(clkEn), .countOut(countQ)
  );

endmodule

// File: rtl/sync_div_align_chk.sv
module sync_div_align_chk
  import sync_div_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RATIO_W   = 3,
  parameter int unsigned CTRL_ADDR = 'h3A,
  parameter int unsigned PIN_ADDR  = 'h59
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regRdData,
  input logic [RATIO_W-1:0] divRatio,
  input logic               clkEn,
  input syncCfg_t           cfg,
  input divStrobe_t         strobe,
  input logic [RATIO_W-1:0] countQ
);

  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] PIN_SEL  = ADDR_W'(PIN_ADDR);

  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == CTRL_SEL);

  assert_realign_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.realign |=> (countQ == '0));

  assert_clken_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && divRatio != '0 && !strobe.realign) |=> (!clkEn || divRatio != $past(divRatio)));

  assert_master_ignore_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.masterEn && countQ < divRatio)
      |=> (countQ == RATIO_W'($past(countQ) + 1'b1) || divRatio != $past(divRatio)));

  assert_oneshot_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.realign && cfg.nextOnly && !ctrlWr) |=> !cfg.divSyncEn);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (cfg.divSyncEn == $past(regWrData[1])));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == PIN_SEL) |-> (regRdData[DATA_W-1:2] == '0));

endmodule

bind sync_div_align sync_div_align_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W),
  .CTRL_ADDR(CTRL_ADDR), .PIN_ADDR(PIN_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
  .regWrEn(regWrEn), .regRdData(regRdData), .divRatio(divRatio),
  .clkEn(clkEn), .cfg(cfgBus), .strobe(strobeBus), .countQ(countQ)
);

// File: tb/sync_div_align_bench.sv
module sync_div_align_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic       syncIn = 1'b0;
  logic [2:0] divRatio = 3'd3;
  logic       clkEn;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curTag = "R1";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  sync_div_align u_sync_div_align (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .syncIn(syncIn),
    .divRatio(divRatio), .clkEn(clkEn)
  );

  // Independent cycle model built from the requirements
  logic       mMaster, mEn, mNext, mEdge, mRise, mS1, mS2, mP;
  logic [2:0] mCount;

  always @(posedge clk) begin : model
    logic qual;
    logic rl;
    if (!rstN) begin
      {mMaster, mEn, mNext, mEdge, mRise, mS1, mS2, mP} <= '0;
      mCount <= 3'd0;
    end else begin
      qual = mEdge ? (mRise ? (mS2 & ~mP) : (~mS2 & mP)) : mS2;
      rl   = mMaster & mEn & qual;
      if (rl) mCount <= 3'd0;
      else if (mCount >= divRatio) mCount <= 3'd0;
      else mCount <= mCount + 3'd1;
      if (regWrEn && regAddr == 8'h3A) {mNext, mEn, mMaster} <= regWrData[2:0];
      else if (rl && mNext) mEn <= 1'b0;
      if (regWrEn && regAddr == 8'h59) {mEdge, mRise} <= regWrData[1:0];
      mS1 <= syncIn;
      mS2 <= mS1;
      mP  <= mS2;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of the divided enable
  always @(negedge clk) begin
    #1;
    if (rstN && !finished)
      check(clkEn == (mCount == divRatio), {curTag, " clkEn"}, int'(clkEn), int'(mCount == divRatio));
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #2;
    check(regRdData == exp, {tag, " read"}, int'(regRdData), int'(exp));
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); syncIn = 1'b1;
    cycles(hi);
    syncIn = 1'b0;
    cycles(lo);
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    cycles(3);
    #3;
    check(regRdData == 8'h00, "R1 reset read 0x00", int'(regRdData), 0);
    check(clkEn == 1'b0, "R1 counter at 0", int'(clkEn), 0);
    @(negedge clk); rstN = 1'b1;
    readReg(8'h3A, 8'h00, "R1");
    readReg(8'h59, 8'h00, "R1");

    curTag = "R2";
    for (int r = 0; r < 8; r++) begin
      @(negedge clk); divRatio = 3'(r);
      cycles(3 * (r + 1) + 2);
    end

    curTag = "R3";
    divRatio = 3'd4;
    writeReg(8'h59, 8'h00);
    writeReg(8'h3A, 8'h06);
    for (int k = 0; k < 4; k++) pulse(k + 1, 3 + k);
    readReg(8'h3A, 8'h06, "R3 enable untouched");

    curTag = "R4";
    writeReg(8'h3A, 8'h01);
    for (int k = 0; k < 4; k++) pulse(k + 2, 2 + k);
    readReg(8'h3A, 8'h01, "R4");

    curTag = "R7";
    writeReg(8'h3A, 8'h03);
    for (int r = 1; r < 8; r++) begin
      @(negedge clk); divRatio = 3'(r);
      for (int ph = 0; ph <= r; ph++) begin
        cycles(ph);
        pulse(3 + (ph % 3), r + 3);
      end
    end
    readReg(8'h3A, 8'h03, "R5 continuous keeps enable");

    curTag = "R8";
    writeReg(8'h59, 8'h03);
    for (int r = 1; r < 8; r += 2) begin
      @(negedge clk); divRatio = 3'(r);
      for (int ph = 0; ph <= r; ph++) begin
        cycles(ph);
        pulse(2 + ph, r + 2);
      end
    end

    curTag = "R9";
    writeReg(8'h59, 8'h02);
    for (int r = 2; r < 8; r += 2) begin
      @(negedge clk); divRatio = 3'(r);
      for (int ph = 0; ph <= r; ph++) begin
        cycles(ph);
        pulse(1 + ph, r + 2);
      end
    end

    curTag = "R6";
    divRatio = 3'd5;
    writeReg(8'h59, 8'h03);
    writeReg(8'h3A, 8'h07);
    cycles(2);
    pulse(2, 5);
    readReg(8'h3A, 8'h05, "R6 edge one-shot cleared");
    for (int k = 0; k < 3; k++) pulse(2, 4 + k);
    readReg(8'h3A, 8'h05, "R6 stays cleared");
    writeReg(8'h59, 8'h00);
    writeReg(8'h3A, 8'h07);
    cycles(3);
    pulse(9, 6);
    readReg(8'h3A, 8'h05, "R6 level one-shot cleared");

    curTag = "R10";
    writeReg(8'h3A, 8'hFF);
    readReg(8'h3A, 8'h07, "R10 ctrl reserved");
    writeReg(8'h59, 8'hFF);
    readReg(8'h59, 8'h03, "R10 pin reserved");
    readReg(8'h10, 8'h00, "R10 unmapped");

    curTag = "R11";
    writeReg(8'h3A, 8'h07);
    writeReg(8'h59, 8'h03);
    cycles(4);
    @(negedge clk); syncIn = 1'b1;
    @(negedge clk);
    @(negedge clk); regWrEn = 1'b1; regAddr = 8'h3A; regWrData = 8'h07;
    @(negedge clk); regWrEn = 1'b0;
    #2;
    check(regRdData == 8'h07, "R11 write wins read", int'(regRdData), 8'h07);
    cycles(4);
    syncIn = 1'b0;
    cycles(4);
    pulse(3, 6);
    readReg(8'h3A, 8'h05, "R11 later event clears");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule